// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is a purely combinational integer arithmetic logic unit for a single-issue integer pipeline. Two operands of `WIDTH` bits (32 by default) enter together with a 3-bit operation code. The unit returns a result word and three flags: zero, signed overflow and carry-out. The datapath is a chain of identical bit slices. Each slice holds a full adder and the two bitwise gates, and a multiplexer picks the output the operation asks for.

A small decoder turns the operation code into a handful of strobes for the datapath. Subtraction reuses the adder: every bit of `b` is inverted and a carry of one is fed into the lowest slice. The signed less-than compare takes the sign of the difference, corrected for overflow, and returns it as a 0/1 value in bit 0. The zero flag is formed from the final result word for every operation. Branch logic can therefore test equality by subtracting and looking at the zero flag.

Top module: `alu32`

## Requirements
- R1: Operation code 3'b000 gives `result = a & b`.
- R2: Operation code 3'b001 gives `result = a | b`.
- R3: Operation code 3'b010 gives `result = a + b` modulo 2^WIDTH. `carryOut` is the carry that leaves the most significant slice.
- R4: Operation code 3'b110 gives `result = a - b`, formed as a + ~b + 1. `carryOut` is the carry leaving the most significant slice, which is 1 exactly when a >= b taken as unsigned values.
- R5: Operation code 3'b111 gives bit 0 = 1 when a < b as signed two's-complement values, else 0. All other result bits are 0. The answer stays correct when a - b overflows.
- R6: `zero` is 1 exactly when every bit of `result` is 0, for every operation code.
- R7: For add, `overflow` is 1 when both operands have the same sign and the result sign differs from it. For subtract, `overflow` is 1 when the operand signs differ and the result sign differs from the sign of `a`.
- R8: For codes 3'b000, 3'b001 and 3'b111, `overflow` and `carryOut` are 0.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 give `result = 0`, `overflow = 0` and `carryOut = 0`, and therefore `zero = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 3 | Operation code |
| result | output | WIDTH | Selected result word |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carryOut | output | 1 | Carry from the top slice for add or subtract |

## Verification
Every output is a function of the current `a`, `b` and `op` only, so each result is due in the same cycle its stimulus is applied, with zero register stages. The driver changes the inputs just after a rising clock edge and queues the expected word and flags. The monitor pops and compares them on the following falling edge, half a period later, when the combinational path has settled. At most one stimulus is in flight per cycle, so the queue order matches the input order exactly.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b110,
    OP_LESS = 3'b111
  } aluOp_e;

  // strobes from decoder to datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic selAnd;
    logic selOr;
    logic selSum;
    logic selLess;
    logic arith;   // add or subtract: flags come from the adder
  } ctrlStrobe_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice (
  input  logic aBit,
  input  logic bBit,
  input  logic invB,
  input  logic cin,
  output logic andBit,
  output logic orBit,
  output logic sumBit,
  output logic cout
);
  logic bx;

  always_comb begin
    bx     = bBit ^ invB;
    andBit = aBit & bx;
    orBit  = aBit | bx;
    sumBit = aBit ^ bx ^ cin;
    cout   = (aBit & bx) | (aBit & cin) | (bx & cin);
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0]  op,
  output ctrlStrobe_t strobe
);
  aluOp_e opCode;

  always_comb begin
    opCode = aluOp_e'(op);
    strobe = '0;
    case (opCode)
      OP_AND:  strobe.selAnd = 1'b1;
      OP_OR:   strobe.selOr  = 1'b1;
      OP_ADD: begin
        strobe.selSum = 1'b1;
        strobe.arith  = 1'b1;
      end
      OP_SUB: begin
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
        strobe.selSum  = 1'b1;
        strobe.arith   = 1'b1;
      end
      OP_LESS: begin
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
        strobe.selLess = 1'b1;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  ctrlStrobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] andVec;
  logic [WIDTH-1:0] orVec;
  logic [WIDTH-1:0] sumVec;
  logic             ovfRaw;
  logic             lessBit;

  assign carry[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    alu_slice uSlice (
      .aBit  (a[i]),
      .bBit  (b[i]),
      .invB  (strobe.invertB),
      .cin   (carry[i]),
      .andBit(andVec[i]),
      .orBit (orVec[i]),
      .sumBit(sumVec[i]),
      .cout  (carry[i+1])
    );
  end

  always_comb begin
    ovfRaw  = carry[MSB] ^ carry[WIDTH];
    lessBit = sumVec[MSB] ^ ovfRaw;   // true sign of a-b
    result  = '0;
    if (strobe.selAnd)  result = andVec;
    if (strobe.selOr)   result = orVec;
    if (strobe.selSum)  result = sumVec;
    if (strobe.selLess) result = {{(WIDTH-1){1'b0}}, lessBit};
    zero     = ~|result;
    overflow = strobe.arith & ovfRaw;
    carryOut = strobe.arith & carry[WIDTH];
  end
endmodule

// File: rtl/alu32.sv
module alu32
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);
  ctrlStrobe_t strobe;

  alu_ctrl uCtrl (
    .op    (op),
    .strobe(strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) uPath (
    .a       (a),
    .b       (b),
    .strobe  (strobe),
    .result  (result),
    .zero    (zero),
    .overflow(overflow),
    .carryOut(carryOut)
  );
endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carryOut
);
  always_comb begin
    // R3
    add_result_chk: assert (op != 3'b010 || result == a + b);
    // R4
    sub_result_chk: assert (op != 3'b110 || result == a - b);
    // R5
    less_result_chk: assert (op != 3'b111 ||
      result == {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))});
    // R8
    no_overflow_chk: assert (!(op == 3'b000 || op == 3'b001 || op == 3'b111) ||
      (!overflow && !carryOut));
    // R9
    unused_code_chk: assert (!(op == 3'b011 || op == 3'b100 || op == 3'b101) ||
      (result == '0 && zero && !overflow && !carryOut));
    // R1
    and_result_chk: assert (op != 3'b000 || result == (a & b));
  end
endmodule

bind alu32 alu32_chk #(.WIDTH(WIDTH)) uChk (
  .a(a), .b(b), .op(op), .result(result),
  .zero(zero), .overflow(overflow), .carryOut(carryOut)
);

// File: tb/sim_alu32.sv
module sim_alu32;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         z;
    logic         o;
    logic         c;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] result;
  logic zero, overflow, carryOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  expItem_t sbQ[$];

  alu32 #(.WIDTH(W)) u0 (
    .a(a), .b(b), .op(op), .result(result),
    .zero(zero), .overflow(overflow), .carryOut(carryOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic expItem_t model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] code);
    expItem_t e;
    logic [W:0] wide;
    e.a = x; e.b = y; e.op = code;
    e.res = '0; e.o = 1'b0; e.c = 1'b0;
    case (code)
      3'b000: begin e.res = x & y; e.tag = "R1"; end
      3'b001: begin e.res = x | y; e.tag = "R2"; end
      3'b010: begin
        wide = {1'b0, x} + {1'b0, y};
        e.res = wide[W-1:0]; e.c = wide[W];
        e.o = (x[W-1] == y[W-1]) && (e.res[W-1] != x[W-1]);
        e.tag = e.o ? "R7" : "R3";
      end
      3'b110: begin
        e.res = x - y; e.c = (x >= y);
        e.o = (x[W-1] != y[W-1]) && (e.res[W-1] != x[W-1]);
        e.tag = e.o ? "R7" : "R4";
      end
      3'b111: begin e.res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))}; e.tag = "R5"; end
      default: e.tag = "R9";
    endcase
    e.z = (e.res == '0);
    if (e.z && (code == 3'b110 || code == 3'b000)) e.tag = {e.tag, "/R6"};
    if (code == 3'b000 || code == 3'b001 || code == 3'b111) e.tag = {e.tag, "/R8"};
    return e;
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] code);
    @(posedge clk);
    #1;
    a = x; b = y; op = code;
    sbQ.push_back(model(x, y, code));
  endtask

  // monitor: result is combinational, due before the falling edge
  always @(negedge clk) begin
    if (!rst && sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      checks++;
      if (result !== e.res || zero !== e.z || overflow !== e.o || carryOut !== e.c) begin
        fails++;
        $display("FAIL %s op=%b a=%h b=%h got res=%h z=%b o=%b c=%b exp res=%h z=%b o=%b c=%b",
                 e.tag, e.op, e.a, e.b, result, zero, overflow, carryOut,
                 e.res, e.z, e.o, e.c);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rs;
    rs = 32'h1234_5679;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: zero inputs, AND -> result 0, zero=1 (R1, R6)
    drive('0, '0, 3'b000);
    // R1, R2 distinct patterns
    drive(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b000);
    drive(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b000);
    drive(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b001);
    drive('0, '0, 3'b001);
    // R3 carry out, R7 overflow corners
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
    drive(32'h8000_0000, 32'h8000_0000, 3'b010);
    drive(32'h0000_0005, 32'h0000_0007, 3'b010);
    // R4, R6 equality through subtract, R7 overflow
    drive(32'h0000_1234, 32'h0000_1234, 3'b110);
    drive(32'h0000_0003, 32'h0000_0005, 3'b110);
    drive(32'h8000_0000, 32'h0000_0001, 3'b110);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    // R5 including overflowing differences
    drive(32'h8000_0000, 32'h0000_0001, 3'b111);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    drive(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);
    drive(32'h0000_0004, 32'h0000_0004, 3'b111);
    // R9 unused codes
    drive(32'hDEAD_BEEF, 32'hFFFF_FFFF, 3'b011);
    drive(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b100);
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b101);
    // pseudo-random sweep over all codes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      x = rs;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      y = (i % 7 == 0) ? x : rs;
      drive(x, y, 3'(i % 8));
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule